// File: doc/BRIEF.md
# SCL Divider Parameter Calculator

This block works out the clock-divider settings for a two-wire serial bus master. Its inputs are the frequency of the bus clock, the frequencies of four prescaled base clocks and a code for the wanted line speed. From these it picks a source clock, a division ratio and the three counts that shape the SCL waveform: the low phase, the high phase and the minimum high phase. All divisions run on one shared iterative restoring divider. One division takes 32 cycles, so a full calculation takes from a few tens to a few hundred cycles.

A one-cycle `start` launches a calculation. The frequency inputs must stay stable while `busy` is high. When the result is ready, `done` pulses for one cycle together with the new outputs, or together with `err` if no setting exists. The outputs keep their values until the next calculation finishes. Software access and clock measurement are handled elsewhere.

Top module: `scl_div_calc`

## Requirements
- R1: `speed_code` 0 selects a 100000 Hz target, 1 selects 400000 Hz and 2 selects 1000000 Hz. Code 3 means a target of zero and finishes with `err`=1.
- R2: The sources are tried in the order bus clock (selector 0), base 1 (1), base 2 (2), base 3 (3). A source at 0 Hz is skipped. The first source whose integer quotient frequency/target is at most 32 is chosen, and its index is reported on `src_sel`.
- R3: The ratio starts as that quotient and is raised by one when frequency/ratio (integer) is still above the target. A quotient of 0 gives a ratio of 1.
- R4: If no direct source fits, base 4 is used with a starting selector of 4. The ratio starts as base4/target with a sticky bit clear. While ratio + sticky exceeds 32, bit 0 of the ratio is ORed into the sticky bit, the ratio is halved (shift right by one) and the selector is incremented. After the loop the sticky bit is added to the ratio and the R3 round-up check is applied against base 4.
- R5: On the base-4 path the ratio is then clamped to the range 1..32 and the selector is reduced to its low 4 bits.
- R6: If no direct source fits and base 4 is 0 Hz, the calculation finishes with `err`=1. On any error `src_sel`, `ratio`, `low_cnt`, `high_cnt` and `high_min_cnt` are 0.
- R7: `low_cnt` = floor(ratio*9/16) - 1, held at 0 if that would go below 0 and capped at 15.
- R8: `high_cnt` = ratio - `low_cnt` - 2, held at 0 if that would go below 0 and capped at 15. `high_min_cnt` = `high_cnt` - 1, held at 0 if that would go below 0.
- R9: `done` is high for exactly one cycle per accepted `start`, and the outputs change only in that cycle. A `start` while `busy` is high is ignored. `busy` rises only in the cycle after an accepted `start`.
- R10: After reset, `busy`, `done` and `err` are 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a calculation |
| speed_code | input | 2 | Target speed: 0 = 100 kHz, 1 = 400 kHz, 2 = 1 MHz, 3 = none |
| bus_clk_hz | input | 32 | Bus clock frequency in Hz (selector 0) |
| base1_hz | input | 32 | Base clock 1 frequency in Hz (selector 1) |
| base2_hz | input | 32 | Base clock 2 frequency in Hz (selector 2) |
| base3_hz | input | 32 | Base clock 3 frequency in Hz (selector 3) |
| base4_hz | input | 32 | Base clock 4 frequency in Hz (fallback source) |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Last calculation found no setting |
| src_sel | output | 4 | Chosen source selector |
| ratio | output | 6 | Chosen division ratio |
| low_cnt | output | 4 | SCL low-phase count |
| high_cnt | output | 4 | SCL high-phase count |
| high_min_cnt | output | 4 | SCL minimum high-phase count |

## Verification
Any wrong internal state shows up on the outputs at the `done` pulse that ends the calculation, which comes a few hundred cycles after `start` at most. A divider that drops a quotient bit skips or selects the wrong source, which shows as a wrong `src_sel`. A sticky bit that is lost or stuck moves `ratio` by one on the base-4 path. A wrong field formula shows directly in the three counts. Broken sequencing shows as a missing or doubled `done`, or as outputs that change between strobes.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_WAIT_Q,
    ST_SHIFT,
    ST_ROUND,
    ST_WAIT_R,
    ST_FIN
  } calc_st_e;

  localparam logic [1:0] SPD_STD   = 2'd0;
  localparam logic [1:0] SPD_FAST  = 2'd1;
  localparam logic [1:0] SPD_FPLUS = 2'd2;

endpackage

// File: rtl/scl_div_divu.sv
module scl_div_divu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         fin,
  output logic [W-1:0] quot
);

  localparam int CNT_W = $clog2(W);

  logic [W-1:0]     rem_q, rem_d;
  logic [W-1:0]     quo_q, quo_d;
  logic [W-1:0]     dsr_q, dsr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             fin_q, fin_d;
  logic [W:0]       rem_sh;
  logic [W:0]       rem_sub;

  always_comb begin
    rem_sh  = {rem_q, quo_q[W-1]};
    rem_sub = rem_sh - {1'b0, dsr_q};
    rem_d   = rem_q;
    quo_d   = quo_q;
    dsr_d   = dsr_q;
    cnt_d   = cnt_q;
    run_d   = run_q;
    fin_d   = 1'b0;
    if (go) begin
      rem_d = '0;
      quo_d = dividend;
      dsr_d = divisor;
      cnt_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      if (rem_sh >= {1'b0, dsr_q}) begin
        rem_d = rem_sub[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_d = rem_sh[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(W - 1)) begin
        run_d = 1'b0;
        fin_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      dsr_q <= dsr_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
      fin_q <= fin_d;
    end
  end

  assign fin  = fin_q;
  assign quot = quo_q;

  // R3: a finished division leaves a remainder below the divisor
  p_rem_below_dsr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> (rem_q < dsr_q));

  // R3: the finish strobe lasts one cycle
  p_fin_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |=> !fin_q);

endmodule

// File: rtl/scl_div_fields.sv
module scl_div_fields #(
  parameter int RATIO_W   = 6,
  parameter int FIELD_W   = 4,
  parameter int LOW_NUM   = 9,
  parameter int LOW_SHIFT = 4
) (
  input  logic [RATIO_W-1:0] ratio,
  output logic [FIELD_W-1:0] low_cnt,
  output logic [FIELD_W-1:0] high_cnt,
  output logic [FIELD_W-1:0] high_min_cnt
);

  localparam int PW = RATIO_W + 5;
  localparam logic [PW-1:0] FMAX = PW'((1 << FIELD_W) - 1);

  logic [PW-1:0] prod, scaled, low_raw, low_cl, edge_sum, ratio_x, high_raw, high_cl;

  always_comb begin
    ratio_x  = PW'(ratio);
    prod     = ratio_x * PW'(LOW_NUM);
    scaled   = prod >> LOW_SHIFT;
    low_raw  = (scaled == '0) ? '0 : scaled - 1'b1;
    low_cl   = (low_raw > FMAX) ? FMAX : low_raw;
    edge_sum = low_cl + PW'(2);
    high_raw = (ratio_x > edge_sum) ? ratio_x - edge_sum : '0;
    high_cl  = (high_raw > FMAX) ? FMAX : high_raw;
    low_cnt      = low_cl[FIELD_W-1:0];
    high_cnt     = high_cl[FIELD_W-1:0];
    high_min_cnt = (high_cl == '0) ? '0 : high_cl[FIELD_W-1:0] - 1'b1;
  end

endmodule

// File: rtl/scl_div_calc.sv
module scl_div_calc #(
  parameter int FREQ_W      = 32,
  parameter int RATIO_LIMIT = 32,
  parameter int SEL_W       = 4,
  parameter int FIELD_W     = 4,
  parameter int STD_HZ      = 100000,
  parameter int FAST_HZ     = 400000,
  parameter int FPLUS_HZ    = 1000000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         speed_code,
  input  logic [31:0]        bus_clk_hz,
  input  logic [31:0]        base1_hz,
  input  logic [31:0]        base2_hz,
  input  logic [31:0]        base3_hz,
  input  logic [31:0]        base4_hz,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [3:0]         src_sel,
  output logic [5:0]         ratio,
  output logic [3:0]         low_cnt,
  output logic [3:0]         high_cnt,
  output logic [3:0]         high_min_cnt
);
  import scl_div_pkg::*;

  localparam int N_DIRECT = 4;
  localparam int IDX_W    = $clog2(N_DIRECT) + 1;
  localparam int RATIO_W  = $clog2(RATIO_LIMIT + 2);
  localparam int SELC_W   = SEL_W + 2;
  localparam logic [FREQ_W-1:0] LIMIT = FREQ_W'(RATIO_LIMIT);

  calc_st_e          st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              fb_q, fb_d;
  logic              sticky_q, sticky_d;
  logic              err_q, err_d;
  logic [SELC_W-1:0] sel_q, sel_d;
  logic [FREQ_W-1:0] rat_q, rat_d;
  logic [FREQ_W-1:0] fsel_q, fsel_d;
  logic [FREQ_W-1:0] tgt_q, tgt_d;
  logic [FREQ_W-1:0] tgt_pick;
  logic [FREQ_W-1:0] cand [N_DIRECT];
  logic [FREQ_W:0]   rat_sum;
  logic [FREQ_W-1:0] rat_clip;
  logic [RATIO_W-1:0] rat_fin;

  logic               done_q, done_d;
  logic               oerr_q, oerr_d;
  logic [SEL_W-1:0]   osel_q, osel_d;
  logic [RATIO_W-1:0] orat_q, orat_d;
  logic [FIELD_W-1:0] olow_q, olow_d, ohigh_q, ohigh_d, ohmin_q, ohmin_d;
  logic [FIELD_W-1:0] f_low, f_high, f_hmin;

  logic              div_go, div_fin;
  logic [FREQ_W-1:0] div_a, div_b, div_q;

  scl_div_divu #(.W(FREQ_W)) u_divu (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (div_a),
    .divisor  (div_b),
    .fin      (div_fin),
    .quot     (div_q)
  );

  scl_div_fields #(
    .RATIO_W   (RATIO_W),
    .FIELD_W   (FIELD_W),
    .LOW_NUM   (9),
    .LOW_SHIFT (4)
  ) u_fields (
    .ratio        (rat_fin),
    .low_cnt      (f_low),
    .high_cnt     (f_high),
    .high_min_cnt (f_hmin)
  );

  always_comb begin
    cand[0] = bus_clk_hz;
    cand[1] = base1_hz;
    cand[2] = base2_hz;
    cand[3] = base3_hz;
    case (speed_code)
      SPD_STD:   tgt_pick = FREQ_W'(STD_HZ);
      SPD_FAST:  tgt_pick = FREQ_W'(FAST_HZ);
      SPD_FPLUS: tgt_pick = FREQ_W'(FPLUS_HZ);
      default:   tgt_pick = '0;
    endcase
  end

  // final ratio: clamp only on the base-4 path, never zero
  always_comb begin
    rat_clip = (fb_q && (rat_q > LIMIT)) ? LIMIT : rat_q;
    if (rat_clip == '0) rat_clip = FREQ_W'(1);
    rat_fin = RATIO_W'(rat_clip);
  end

  // sequencing next state
  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    fb_d     = fb_q;
    sticky_d = sticky_q;
    err_d    = err_q;
    sel_d    = sel_q;
    rat_d    = rat_q;
    fsel_d   = fsel_q;
    tgt_d    = tgt_q;
    div_go   = 1'b0;
    div_a    = fsel_q;
    div_b    = tgt_q;
    rat_sum  = {1'b0, rat_q} + {{FREQ_W{1'b0}}, sticky_q};
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          tgt_d    = tgt_pick;
          idx_d    = '0;
          fb_d     = 1'b0;
          sticky_d = 1'b0;
          sel_d    = '0;
          rat_d    = '0;
          if (tgt_pick == '0) begin
            err_d = 1'b1;
            st_d  = ST_FIN;
          end else begin
            err_d = 1'b0;
            st_d  = ST_PICK;
          end
        end
      end
      ST_PICK: begin
        if (idx_q == IDX_W'(N_DIRECT)) begin
          if (base4_hz == '0) begin
            err_d = 1'b1;
            st_d  = ST_FIN;
          end else begin
            fb_d   = 1'b1;
            fsel_d = base4_hz;
            sel_d  = SELC_W'(N_DIRECT);
            div_go = 1'b1;
            div_a  = base4_hz;
            st_d   = ST_WAIT_Q;
          end
        end else if (cand[idx_q[IDX_W-2:0]] == '0) begin
          idx_d = idx_q + 1'b1;
        end else begin
          fsel_d = cand[idx_q[IDX_W-2:0]];
          sel_d  = SELC_W'(idx_q);
          div_go = 1'b1;
          div_a  = cand[idx_q[IDX_W-2:0]];
          st_d   = ST_WAIT_Q;
        end
      end
      ST_WAIT_Q: begin
        if (div_fin) begin
          if (fb_q) begin
            rat_d = div_q;
            st_d  = ST_SHIFT;
          end else if (div_q <= LIMIT) begin
            rat_d = div_q;
            st_d  = ST_ROUND;
          end else begin
            idx_d = idx_q + 1'b1;
            st_d  = ST_PICK;
          end
        end
      end
      ST_SHIFT: begin
        if (rat_sum > {1'b0, LIMIT}) begin
          sticky_d = sticky_q | rat_q[0];
          rat_d    = rat_q >> 1;
          sel_d    = sel_q + 1'b1;
        end else begin
          rat_d = rat_sum[FREQ_W-1:0];
          st_d  = ST_ROUND;
        end
      end
      ST_ROUND: begin
        if (rat_q != '0) begin
          div_go = 1'b1;
          div_b  = rat_q;
          st_d   = ST_WAIT_R;
        end else begin
          st_d = ST_FIN;
        end
      end
      ST_WAIT_R: begin
        if (div_fin) begin
          if (div_q > tgt_q) rat_d = rat_q + 1'b1;
          st_d = ST_FIN;
        end
      end
      ST_FIN: begin
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // result next state
  always_comb begin
    done_d  = 1'b0;
    oerr_d  = oerr_q;
    osel_d  = osel_q;
    orat_d  = orat_q;
    olow_d  = olow_q;
    ohigh_d = ohigh_q;
    ohmin_d = ohmin_q;
    if (st_q == ST_FIN) begin
      done_d = 1'b1;
      oerr_d = err_q;
      if (err_q) begin
        osel_d  = '0;
        orat_d  = '0;
        olow_d  = '0;
        ohigh_d = '0;
        ohmin_d = '0;
      end else begin
        osel_d  = sel_q[SEL_W-1:0];
        orat_d  = rat_fin;
        olow_d  = f_low;
        ohigh_d = f_high;
        ohmin_d = f_hmin;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      fb_q     <= 1'b0;
      sticky_q <= 1'b0;
      err_q    <= 1'b0;
      sel_q    <= '0;
      rat_q    <= '0;
      fsel_q   <= '0;
      tgt_q    <= '0;
      done_q   <= 1'b0;
      oerr_q   <= 1'b0;
      osel_q   <= '0;
      orat_q   <= '0;
      olow_q   <= '0;
      ohigh_q  <= '0;
      ohmin_q  <= '0;
    end else begin
      st_q     <= st_d;
      idx_q    <= idx_d;
      fb_q     <= fb_d;
      sticky_q <= sticky_d;
      err_q    <= err_d;
      sel_q    <= sel_d;
      rat_q    <= rat_d;
      fsel_q   <= fsel_d;
      tgt_q    <= tgt_d;
      done_q   <= done_d;
      oerr_q   <= oerr_d;
      osel_q   <= osel_d;
      orat_q   <= orat_d;
      olow_q   <= olow_d;
      ohigh_q  <= ohigh_d;
      ohmin_q  <= ohmin_d;
    end
  end

  assign busy         = (st_q != ST_IDLE);
  assign done         = done_q;
  assign err          = oerr_q;
  assign src_sel      = osel_q;
  assign ratio        = orat_q;
  assign low_cnt      = olow_q;
  assign high_cnt     = ohigh_q;
  assign high_min_cnt = ohmin_q;

  // R9: done is a single-cycle strobe
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9: results move only together with done
  p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable({oerr_q, osel_q, orat_q, olow_q, ohigh_q, ohmin_q}));

  // R9: a calculation begins only on a start request
  p_busy_from_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R5: a successful result carries a ratio of at least one and at most one over the limit
  p_ratio_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !oerr_q) |-> (orat_q != '0 && orat_q <= RATIO_W'(RATIO_LIMIT + 1)));

  // R6: an error result clears the selector and ratio
  p_err_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && oerr_q) |-> (orat_q == '0 && osel_q == '0));

endmodule

// File: tb/test_scl_div_calc.sv
module test_scl_div_calc;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [1:0]  speed_code;
  logic [31:0] bus_clk_hz, base1_hz, base2_hz, base3_hz, base4_hz;
  logic        busy, done, err;
  logic [3:0]  src_sel, low_cnt, high_cnt, high_min_cnt;
  logic [5:0]  ratio;

  int n_vec;
  int n_bad;
  logic [15:0] lfsr;

  scl_div_calc i_scl_div_calc (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .speed_code   (speed_code),
    .bus_clk_hz   (bus_clk_hz),
    .base1_hz     (base1_hz),
    .base2_hz     (base2_hz),
    .base3_hz     (base3_hz),
    .base4_hz     (base4_hz),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .src_sel      (src_sel),
    .ratio        (ratio),
    .low_cnt      (low_cnt),
    .high_cnt     (high_cnt),
    .high_min_cnt (high_min_cnt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected result: {err, sel[3:0], ratio[5:0], low[3:0], high[3:0], hmin[3:0]}
  function automatic logic [22:0] model(input int code, input longint f0, input longint f1,
                                        input longint f2, input longint f3, input longint f4);
    longint tgt, q, r, c, lo, hi, hm, s, inc;
    longint cs [4];
    bit found;
    cs[0] = f0; cs[1] = f1; cs[2] = f2; cs[3] = f3;
    tgt = (code == 0) ? 100000 : (code == 1) ? 400000 : (code == 2) ? 1000000 : 0;
    if (tgt == 0) return {1'b1, 22'd0};
    found = 0; r = 0; s = 0;
    for (int i = 0; i < 4; i++) begin
      c = cs[i];
      if (!found && c != 0) begin
        q = c / tgt;
        if (q <= 32) begin
          r = q;
          if (r > 0 && c / r > tgt) r++;
          if (r == 0) r = 1;
          s = i;
          found = 1;
        end
      end
    end
    if (!found) begin
      if (f4 == 0) return {1'b1, 22'd0};
      s = 4; r = f4 / tgt; inc = 0;
      while (r + inc > 32) begin
        inc = inc | (r & 1);
        r = r >> 1;
        s++;
      end
      r = r + inc;
      if (r > 0 && f4 / r > tgt) r++;
      if (r > 32) r = 32;
      if (r == 0) r = 1;
      s = s & 15;
    end
    lo = (r * 9) / 16 - 1;
    if (lo < 0) lo = 0;
    if (lo > 15) lo = 15;
    hi = r - lo - 2;
    if (hi < 0) hi = 0;
    if (hi > 15) hi = 15;
    hm = (hi > 0) ? hi - 1 : 0;
    return {1'b0, s[3:0], r[5:0], lo[3:0], hi[3:0], hm[3:0]};
  endfunction

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int k = 0; k < 3000 && !seen; k++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
  endtask

  task automatic run_vec(input string req, input int code, input longint f0, input longint f1,
                         input longint f2, input longint f3, input longint f4);
    logic [22:0] e;
    logic [22:0] got;
    bit seen;
    e = model(code, f0, f1, f2, f3, f4);
    @(negedge clk);
    speed_code = code[1:0];
    bus_clk_hz = f0[31:0]; base1_hz = f1[31:0]; base2_hz = f2[31:0];
    base3_hz = f3[31:0]; base4_hz = f4[31:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(seen);
    check(seen, {req, " done strobe"}, seen, 1);
    if (seen) begin
      got = {err, src_sel, ratio, low_cnt, high_cnt, high_min_cnt};
      check(got[22:12] == e[22:12], {req, " err/sel/ratio"}, got[22:12], e[22:12]);
      check(got[11:8] == e[11:8], "R7 low_cnt", got[11:8], e[11:8]);
      check(got[7:0] == e[7:0], "R8 high/high_min", got[7:0], e[7:0]);
      @(negedge clk);
      check(!done, "R9 done one cycle", done, 0);
    end
  endtask

  function automatic longint pick(input logic [2:0] k);
    case (k)
      3'd0: return 0;
      3'd1: return 50000;
      3'd2: return 1000000;
      3'd3: return 2777777;
      3'd4: return 10000000;
      3'd5: return 20000000;
      3'd6: return 50000000;
      default: return 64'hFFFF_FFFF;
    endcase
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    n_vec = 0; n_bad = 0; lfsr = 16'hACE1;
    rst_n = 1'b0; start = 1'b0; speed_code = 2'd0;
    bus_clk_hz = '0; base1_hz = '0; base2_hz = '0; base3_hz = '0; base4_hz = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!busy && !done && !err, "R10 flags after reset", {busy, done, err}, 0);
    check({src_sel, ratio, low_cnt, high_cnt, high_min_cnt} == '0, "R10 results after reset",
          {src_sel, ratio, low_cnt, high_cnt, high_min_cnt}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: default clocks at all speeds
    for (int sp = 0; sp < 3; sp++)
      run_vec("R1", sp, 50000000, 20000000, 10000000, 2777777, 1000000);
    // R1: speed code 3 is an error
    run_vec("R1 code3", 3, 50000000, 20000000, 10000000, 2777777, 1000000);
    // R2: zero-frequency sources skipped
    run_vec("R2 skip", 1, 0, 0, 10000000, 2777777, 1000000);
    // R3: quotient of zero forced to one
    run_vec("R3 zero", 0, 50000, 20000000, 10000000, 2777777, 1000000);
    // R4: base-4 fallback with shifting and sticky
    run_vec("R4 shift", 0, 0, 0, 0, 0, 50000000);
    run_vec("R4 deep", 0, 0, 0, 0, 0, 64'hFFFF_FFFF);
    run_vec("R4 fplus", 2, 64'hFFFF_FFFF, 0, 0, 0, 64'hFFFF_FFFF);
    // R5: clamp on fallback
    run_vec("R5 clamp", 1, 0, 0, 0, 0, 13000000);
    // R6: no source at all
    run_vec("R6 none", 0, 0, 0, 0, 0, 0);
    run_vec("R6 fast", 2, 64'hFFFF_FFFF, 50000000, 0, 0, 0);

    // R2: sweep of source mixes over all speed codes
    for (int sp = 0; sp < 4; sp++) begin
      for (int n = 0; n < 45; n++) begin
        step_lfsr();
        run_vec("R2 sweep", sp, pick(lfsr[2:0]), pick(lfsr[5:3]), pick(lfsr[8:6]),
                pick(lfsr[11:9]), pick({lfsr[0], lfsr[15:14]}));
      end
    end

    // R9: start during busy is ignored
    begin
      logic [22:0] e;
      bit seen;
      e = model(0, 50000000, 20000000, 10000000, 2777777, 1000000);
      @(negedge clk);
      speed_code = 2'd0;
      bus_clk_hz = 50000000; base1_hz = 20000000; base2_hz = 10000000;
      base3_hz = 2777777; base4_hz = 1000000;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      check(busy, "R9 busy during calc", busy, 1);
      speed_code = 2'd2; start = 1'b1;
      @(negedge clk);
      start = 1'b0; speed_code = 2'd0;
      wait_done(seen);
      check(seen && ({err, src_sel, ratio} == e[22:12]), "R9 start while busy",
            {err, src_sel, ratio}, e[22:12]);
      @(negedge clk);
      check(!busy && !done, "R9 no second calc", {busy, done}, 0);
      // R9: outputs hold without a start
      speed_code = 2'd3; bus_clk_hz = '0; base3_hz = '0;
      repeat (60) @(negedge clk);
      check(!done && !busy, "R9 idle without start", {busy, done}, 0);
      check({err, src_sel, ratio, low_cnt, high_cnt, high_min_cnt} == e,
            "R9 hold results", {err, src_sel, ratio, low_cnt, high_cnt, high_min_cnt}, e);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule